// File: doc/BRIEF.md
# Two-Port Trace Stream Replicator

The block takes one incoming trace stream that uses a valid/ready handshake and offers every beat to two output ports. A beat carries a 7-bit source ID and a data word. Each output port has its own 8-bit range mask. The top three bits of the source ID select one bit of that mask, and a set bit removes the beat from that port only. The input beat retires only when every port that still wants it has taken it. A port that has already taken the beat is marked done, so it never receives the same beat twice.

A small register port, with a write strobe, a word address and combinational read data, holds the two masks and the mode control. It also gives access to the integration features. In integration mode, software drives the two output valids and the input ready from a register, and it reads the live output readies and the input valid from another register.

A three-state controller sequences the beat and the mode. The states are `ST_FRESH`, `ST_PARTIAL` and `ST_INTEG`:
- `ST_FRESH`: no port has taken the current beat.
- `ST_PARTIAL`: at least one port has taken the beat, and another port is still due.
- `ST_INTEG`: integration mode.

The transitions are:
- *take*: `ST_FRESH` to `ST_PARTIAL`, when a port accepts but the beat does not retire.
- *retire*: `ST_PARTIAL` to `ST_FRESH`, when the last due port accepts.
- *enter*: any state to `ST_INTEG`, on a write of 1 to the mode register.
- *leave*: `ST_INTEG` to `ST_FRESH`, on a write of 0 to the mode register.

Top module: `trace_fanout`

## Requirements
- R1: After reset, both output valids are 0. The input ready is 1 while no beat is offered. The mask, mode and drive registers all read 0.
- R2: In functional mode, an unmasked beat appears on both ports with the input ID and data. The input ready is 1 only in a cycle in which every port that still wants the beat has its ready high.
- R3: A port that accepts a beat before the other port drops its valid from the next cycle. It never accepts that beat a second time.
- R4: Mask register address 0 serves port 0, and address 1 serves port 1. Both use bits [7:0]. Bit i set removes IDs 0x(i)0 to 0x(i)F from that port only.
- R5: A beat that is masked on both ports is dropped at once. Both output valids stay 0 and the input ready is 1 in the same cycle.
- R6: In functional mode, while a port's valid is high and its ready is low, that port's valid, ID and data stay unchanged into the next cycle, provided the source holds its beat.
- R7: Address 5 reads the number of output ports, which is 2. Writes to address 5 have no effect.
- R8: Address 2 bit 0 enables integration mode, and it reads back the current mode.
- R9: Address 3 is the drive register. Bit 0 drives the port 0 valid, bit 1 drives the port 1 valid, and bit 2 drives the input ready. These bits act only in integration mode and have no effect in functional mode.
- R10: Address 4 reads the sense bits. Bit 0 is the port 0 ready, bit 1 is the port 1 ready, and bit 2 is the input valid. The values are live in integration mode, and the register reads 0 in functional mode.
- R11: Leaving integration mode clears every port's taken mark. A beat that is still pending is then offered again to both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_id | input | 7 | Source ID of the input beat |
| in_data | input | 32 | Data of the input beat |
| out_valid | output | 2 | Valid per port, with bit p for port p |
| out_ready | input | 2 | Ready per port |
| out_id | output | 14 | Port p ID at bits [7p+6:7p] |
| out_data | output | 64 | Port p data at bits [32p+31:32p] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |

## Verification
The assertions check the following on every cycle:
- Data holding under backpressure.
- That no port repeats an accepted beat.
- That a retiring beat leaves no due port unready.
- That the controller state agrees with the ports' taken marks.

Only the scenarios can show the mask decode at range edges and the register encodings. The same holds for the drive and sense paths of integration mode, for the no-effect cases, and for the re-offer of a pending beat after integration mode ends.

// File: rtl/trc_fan_pkg.sv
package trc_fan_pkg;
    localparam int NPORTS    = 2;
    localparam int GRP_SHIFT = 4;
    localparam int ADDR_W    = 3;
    localparam int DRV_W     = NPORTS + 1;

    typedef enum logic [1:0] {
        ST_FRESH   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_INTEG   = 2'd2
    } fan_state_e;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DRIVE = 3'd3;
    localparam logic [ADDR_W-1:0] A_SENSE = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAPS  = 3'd5;
endpackage

// File: rtl/trc_fan_regs.sv
module trc_fan_regs
    import trc_fan_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int NGRP  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    input  logic                   integ_on,
    input  logic [DRV_W-1:0]       sense_live,
    output logic [NPORTS*NGRP-1:0] filt,
    output logic [DRV_W-1:0]       drive,
    output logic                   mode_wr,
    output logic                   mode_val
);
    logic [NGRP-1:0]  filt_q [NPORTS];
    logic [DRV_W-1:0] drive_q;

    for (genvar p = 0; p < NPORTS; p++) begin : g_filt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                filt_q[p] <= '0;
            end else if (reg_we && reg_addr == ADDR_W'(p)) begin
                filt_q[p] <= reg_wdata[NGRP-1:0];
            end
        end
        assign filt[p*NGRP +: NGRP] = filt_q[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '0;
        end else if (reg_we && reg_addr == A_DRIVE) begin
            drive_q <= reg_wdata[DRV_W-1:0];
        end
    end

    assign drive    = drive_q;
    assign mode_wr  = reg_we && (reg_addr == A_MODE);
    assign mode_val = reg_wdata[0];

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (reg_addr == ADDR_W'(p)) reg_rdata[NGRP-1:0] = filt_q[p];
        end
        case (reg_addr)
            A_MODE:  reg_rdata[0] = integ_on;
            A_DRIVE: reg_rdata[DRV_W-1:0] = drive_q;
            A_SENSE: reg_rdata[DRV_W-1:0] = integ_on ? sense_live : '0;
            A_CAPS:  reg_rdata = REG_W'(NPORTS);
            default: ;
        endcase
    end
endmodule

// File: rtl/trc_fan_lane.sv
module trc_fan_lane
    import trc_fan_pkg::*;
#(
    parameter int ID_W   = 7,
    parameter int DATA_W = 32,
    parameter int NGRP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NGRP-1:0]   filt,
    input  logic              in_valid,
    input  logic [ID_W-1:0]   in_id,
    input  logic [DATA_W-1:0] in_data,
    input  logic              integ,
    input  logic              integ_valid,
    input  logic              out_ready,
    input  logic              beat_done,
    output logic              out_valid,
    output logic [ID_W-1:0]   out_id,
    output logic [DATA_W-1:0] out_data,
    output logic              lane_done,
    output logic              lane_took,
    output logic              taken
);
    localparam int GRP_W = ID_W - GRP_SHIFT;

    logic [GRP_W-1:0] grp;
    logic             pass;
    logic             need;
    logic             taken_q;

    assign grp       = in_id[ID_W-1:GRP_SHIFT];
    assign pass      = !filt[grp];
    assign need      = in_valid && pass && !taken_q;
    assign out_valid = integ ? integ_valid : need;
    assign out_id    = in_id;
    assign out_data  = in_data;
    assign lane_took = !integ && need && out_ready;
    assign lane_done = !need || out_ready;
    assign taken     = taken_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
        end else if (integ || beat_done) begin
            taken_q <= 1'b0;
        end else if (lane_took) begin
            taken_q <= 1'b1;
        end
    end
endmodule

// File: rtl/trc_fan_ctrl.sv
module trc_fan_ctrl
    import trc_fan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [NPORTS-1:0] lane_done,
    input  logic [NPORTS-1:0] lane_took,
    input  logic              mode_wr,
    input  logic              mode_val,
    input  logic              drive_in_ready,
    output logic              in_ready,
    output logic              beat_done,
    output logic              integ,
    output fan_state_e        state
);
    fan_state_e state_q;
    fan_state_e state_d;
    logic       all_done;

    assign all_done = &lane_done;
    assign state    = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FRESH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (mode_wr && mode_val) begin
            state_d = ST_INTEG;
        end else begin
            unique case (state_q)
                ST_FRESH: begin
                    if (in_valid && all_done) state_d = ST_FRESH;
                    else if (|lane_took)      state_d = ST_PARTIAL;
                end
                ST_PARTIAL: begin
                    if (in_valid && all_done) state_d = ST_FRESH;
                end
                ST_INTEG: begin
                    if (mode_wr) state_d = ST_FRESH;
                end
                default: state_d = ST_FRESH;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_INTEG: begin
                integ     = 1'b1;
                in_ready  = drive_in_ready;
                beat_done = 1'b0;
            end
            default: begin
                integ     = 1'b0;
                in_ready  = all_done;
                beat_done = in_valid && all_done;
            end
        endcase
    end
endmodule

// File: rtl/trace_fanout.sv
module trace_fanout
    import trc_fan_pkg::*;
#(
    parameter int ID_W   = 7,
    parameter int DATA_W = 32,
    parameter int REG_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [ID_W-1:0]          in_id,
    input  logic [DATA_W-1:0]        in_data,
    output logic [NPORTS-1:0]        out_valid,
    input  logic [NPORTS-1:0]        out_ready,
    output logic [NPORTS*ID_W-1:0]   out_id,
    output logic [NPORTS*DATA_W-1:0] out_data,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata
);
    localparam int NGRP = 1 << (ID_W - GRP_SHIFT);

    logic [NPORTS*NGRP-1:0] filt;
    logic [DRV_W-1:0]       drive;
    logic [DRV_W-1:0]       sense_live;
    logic                   mode_wr;
    logic                   mode_val;
    logic                   integ;
    logic                   beat_done;
    logic [NPORTS-1:0]      lane_done;
    logic [NPORTS-1:0]      lane_took;
    logic [NPORTS-1:0]      lane_taken;
    fan_state_e             state;

    assign sense_live = {in_valid, out_ready};

    trc_fan_regs #(.REG_W(REG_W), .NGRP(NGRP)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .integ_on   (integ),
        .sense_live (sense_live),
        .filt       (filt),
        .drive      (drive),
        .mode_wr    (mode_wr),
        .mode_val   (mode_val)
    );

    trc_fan_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .lane_done      (lane_done),
        .lane_took      (lane_took),
        .mode_wr        (mode_wr),
        .mode_val       (mode_val),
        .drive_in_ready (drive[NPORTS]),
        .in_ready       (in_ready),
        .beat_done      (beat_done),
        .integ          (integ),
        .state          (state)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_lane
        trc_fan_lane #(.ID_W(ID_W), .DATA_W(DATA_W), .NGRP(NGRP)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .filt        (filt[p*NGRP +: NGRP]),
            .in_valid    (in_valid),
            .in_id       (in_id),
            .in_data     (in_data),
            .integ       (integ),
            .integ_valid (drive[p]),
            .out_ready   (out_ready[p]),
            .beat_done   (beat_done),
            .out_valid   (out_valid[p]),
            .out_id      (out_id[p*ID_W +: ID_W]),
            .out_data    (out_data[p*DATA_W +: DATA_W]),
            .lane_done   (lane_done[p]),
            .lane_took   (lane_took[p]),
            .taken       (lane_taken[p])
        );
    end
endmodule

// File: rtl/trc_fan_chk.sv
module trc_fan_chk
    import trc_fan_pkg::*;
#(
    parameter int ID_W   = 7,
    parameter int DATA_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic [NPORTS-1:0]        out_valid,
    input logic [NPORTS-1:0]        out_ready,
    input logic [NPORTS*ID_W-1:0]   out_id,
    input logic [NPORTS*DATA_W-1:0] out_data,
    input logic [NPORTS-1:0]        lane_taken,
    input fan_state_e               state
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (state != ST_INTEG && out_valid[p] && !out_ready[p]) |=>
            (state == ST_INTEG) ||
            (out_valid[p] && $stable(out_id[p*ID_W +: ID_W]) &&
             $stable(out_data[p*DATA_W +: DATA_W])));

        p_no_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (state != ST_INTEG && out_valid[p] && out_ready[p] && !(in_valid && in_ready)) |=>
            (state == ST_INTEG) || !out_valid[p]);

        p_retire_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (state != ST_INTEG && in_valid && in_ready) |-> (out_ready[p] || !out_valid[p]));
    end

    p_valid_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_INTEG && (|out_valid)) |-> in_valid);

    p_fresh_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRESH) |-> (lane_taken == '0));

    p_partial_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARTIAL) |-> (lane_taken != '0));
endmodule

bind trace_fanout trc_fan_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_id     (out_id),
    .out_data   (out_data),
    .lane_taken (lane_taken),
    .state      (state)
);

// File: tb/tb_trace_fanout.sv
`timescale 1ns/1ps
module tb_trace_fanout;
    localparam int ID_W   = 7;
    localparam int DATA_W = 32;
    localparam int REG_W  = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [ID_W-1:0]     in_id = '0;
    logic [DATA_W-1:0]   in_data = '0;
    logic [1:0]          out_valid;
    logic [1:0]          out_ready = 2'b00;
    logic [2*ID_W-1:0]   out_id;
    logic [2*DATA_W-1:0] out_data;
    logic                reg_we = 1'b0;
    logic [2:0]          reg_addr = '0;
    logic [REG_W-1:0]    reg_wdata = '0;
    logic [REG_W-1:0]    reg_rdata;

    int total = 0;
    int bad   = 0;
    int hs0   = 0;
    int hs1   = 0;

    always #2.5 clk = ~clk;

    trace_fanout dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_id(in_id), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_id(out_id), .out_data(out_data), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (rst_n && out_valid[0] && out_ready[0]) hs0++;
        if (rst_n && out_valid[1] && out_ready[1]) hs1++;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rdchk(input string req, input logic [2:0] a, input logic [REG_W-1:0] exp);
        reg_addr = a;
        #1;
        chk(req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R1 valids", 64'(out_valid), 64'h0);
        chk("R1 in_ready idle", 64'(in_ready), 64'h1);
        rdchk("R1 mask0", 3'd0, 8'h00);
        rdchk("R1 mask1", 3'd1, 8'h00);
        rdchk("R1 mode", 3'd2, 8'h00);
        rdchk("R1 drive", 3'd3, 8'h00);
        rdchk("R7 caps", 3'd5, 8'h02);
        wr(3'd5, 8'hFF);
        rdchk("R7 caps after write", 3'd5, 8'h02);
        out_ready = 2'b11;
        rdchk("R10 sense zero in functional", 3'd4, 8'h00);
        wr(3'd3, 8'h07);
        chk("R9 drive no effect valid", 64'(out_valid), 64'h0);
        chk("R9 drive no effect ready", 64'(in_ready), 64'h1);
        out_ready = 2'b00;
    endtask

    task automatic t_broadcast;
        @(negedge clk);
        out_ready = 2'b11; in_valid = 1'b1; in_id = 7'h23; in_data = 32'hA5A5_0001;
        #1;
        chk("R2 both valid", 64'(out_valid), 64'h3);
        chk("R2 ids", 64'(out_id), 64'({7'h23, 7'h23}));
        chk("R2 data", out_data, {32'hA5A5_0001, 32'hA5A5_0001});
        chk("R2 ready", 64'(in_ready), 64'h1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_backpressure;
        int h0;
        int h1;
        @(negedge clk);
        h0 = hs0; h1 = hs1;
        out_ready = 2'b01; in_valid = 1'b1; in_id = 7'h41; in_data = 32'h1234_5678;
        #1;
        chk("R2 wait both valid", 64'(out_valid), 64'h3);
        chk("R2 held ready low", 64'(in_ready), 64'h0);
        step();
        chk("R3 port0 dropped", 64'(out_valid), 64'h2);
        chk("R2 still waiting", 64'(in_ready), 64'h0);
        step();
        chk("R6 port1 data held", 64'(out_data[63:32]), 64'h1234_5678);
        chk("R6 port1 id held", 64'(out_id[13:7]), 64'h41);
        out_ready = 2'b10;
        #1;
        chk("R2 retire", 64'(in_ready), 64'h1);
        chk("R3 port0 stays quiet", 64'(out_valid), 64'h2);
        @(negedge clk);
        in_valid = 1'b0; out_ready = 2'b00;
        #1;
        chk("R3 port0 single accept", 64'(hs0 - h0), 64'h1);
        chk("R3 port1 single accept", 64'(hs1 - h1), 64'h1);
    endtask

    task automatic t_filter;
        wr(3'd0, 8'h04);
        out_ready = 2'b11; in_valid = 1'b1; in_id = 7'h25;
        #1;
        chk("R4 0x25 masked port0", 64'(out_valid), 64'h2);
        step();
        in_id = 7'h35; #1;
        chk("R4 0x35 passes", 64'(out_valid), 64'h3);
        step();
        in_id = 7'h2F; #1;
        chk("R4 0x2F masked port0", 64'(out_valid), 64'h2);
        step();
        in_id = 7'h1F; #1;
        chk("R4 0x1F passes", 64'(out_valid), 64'h3);
        @(negedge clk);
        in_valid = 1'b0;
        rdchk("R4 mask0 readback", 3'd0, 8'h04);
    endtask

    task automatic t_both_masked;
        wr(3'd1, 8'h04);
        rdchk("R4 mask1 readback", 3'd1, 8'h04);
        out_ready = 2'b00; in_valid = 1'b1; in_id = 7'h21;
        #1;
        chk("R5 no valids", 64'(out_valid), 64'h0);
        chk("R5 dropped at once", 64'(in_ready), 64'h1);
        step();
        in_id = 7'h31; #1;
        chk("R5 other range kept", 64'(out_valid), 64'h3);
        chk("R5 other range waits", 64'(in_ready), 64'h0);
        out_ready = 2'b11;
        @(negedge clk);
        in_valid = 1'b0; out_ready = 2'b00;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_integ;
        wr(3'd3, 8'h05);
        wr(3'd2, 8'h01);
        rdchk("R8 mode readback", 3'd2, 8'h01);
        chk("R9 drive valids", 64'(out_valid), 64'h1);
        chk("R9 drive ready", 64'(in_ready), 64'h1);
        out_ready = 2'b10; in_valid = 1'b1;
        rdchk("R10 sense live", 3'd4, 8'h06);
        wr(3'd3, 8'h02);
        chk("R9 drive valids 2", 64'(out_valid), 64'h2);
        chk("R9 drive ready 2", 64'(in_ready), 64'h0);
        in_valid = 1'b0; out_ready = 2'b00;
        wr(3'd2, 8'h00);
        rdchk("R8 mode cleared", 3'd2, 8'h00);
    endtask

    task automatic t_exit;
        @(negedge clk);
        in_valid = 1'b1; in_id = 7'h10; in_data = 32'hCAFE_0010; out_ready = 2'b01;
        step();
        chk("R3 port0 took", 64'(out_valid), 64'h2);
        wr(3'd2, 8'h01);
        wr(3'd2, 8'h00);
        chk("R11 re-offered", 64'(out_valid), 64'h3);
        chk("R11 waiting", 64'(in_ready), 64'h0);
        out_ready = 2'b11;
        @(negedge clk);
        in_valid = 1'b0; out_ready = 2'b00;
        #1;
        chk("R11 retired", 64'(out_valid), 64'h0);
    endtask

    initial begin
        #(5.0 * 50000);
        total++; bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_broadcast();
        t_backpressure();
        t_filter();
        t_both_masked();
        t_integ();
        t_exit();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule